// File: doc/BRIEF.md
# All-ones alarm detector

This block watches the decoded receive bit stream and raises a level alarm when the incoming data is, for practical purposes, nothing but ones. A receive bit is presented together with a qualifier on each clock. Windows for counting are bounded by an external periodic strobe, which may be asynchronous to the clock. The block synchronizes the strobe, and each rising edge of the synchronized strobe closes one window and opens the next.

Within a window the block counts received zeros with a small saturating counter. At every window boundary it records whether the closing window held fewer than the threshold number of zeros (three by default). The alarm is set after two back-to-back windows are both short of zeros. It is cleared after two back-to-back windows both reach the threshold. A mixed pair of windows leaves the alarm unchanged. Between boundaries the alarm never moves.

Top module: `allones_alarm`

## Requirements
- R1: While rst_n is low and directly after its release, alarm is 0. Reset also clears the zero count and the memory of the previous window.
- R2: A bit counts as a zero only when bit_valid is 1 and bit_in is 0. Ones, and any bit presented with bit_valid at 0, are not counted. The count saturates at ZERO_LIMIT (3), and extra zeros have no further effect.
- R3: A window boundary is one rising edge of win_strobe seen through a SYNC_STAGES-flop synchronizer (default 2). If win_strobe is first sampled high at clock edge k, the boundary takes effect at edge k+SYNC_STAGES. Holding win_strobe high for many cycles produces exactly one boundary.
- R4: When two consecutive windows each close with fewer than ZERO_LIMIT zeros, alarm is 1 right after the second boundary.
- R5: When two consecutive windows each close with at least ZERO_LIMIT zeros, alarm is 0 right after the second boundary.
- R6: alarm changes only at a boundary. A boundary that closes a pair with one short window and one full window leaves alarm unchanged.
- R7: A zero presented in the boundary cycle belongs to the new window. The closing window's result uses only the bits before it, and the new window starts with a count of 1.
- R8: The first window after reset has no predecessor, so its boundary cannot change alarm. The span from reset release to the first boundary counts as a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | High when bit_in carries a received bit this cycle |
| bit_in | input | 1 | Decoded receive bit |
| win_strobe | input | 1 | External window strobe, possibly asynchronous |
| alarm | output | 1 | All-ones alarm level |

## Verification
The boundary and the zero counter can act in the same cycle: a qualified zero can arrive exactly when the synchronized strobe edge closes a window. The bench places a zero in that cycle, between two windows that each hold two ordinary zeros. The alarm is then judged on the next two boundaries. The alarm must set because the closing window stayed at two. It must later see three in the following window, because the carried zero started that window's count at one.

// File: rtl/aa_pkg.sv
package aa_pkg;

    // Per-window verdict memory and the alarm it drives.
    typedef struct packed {
        logic hist_valid;   // a closed window exists since reset
        logic hist_enough;  // that window reached the zero threshold
        logic alarm;
    } judge_t;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/aa_strobe_edge.sv
module aa_strobe_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic edge_o
);
    localparam int unsigned LEN = SYNC_STAGES + 1;

    logic [LEN-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[LEN-2:0], strobe_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    // Synchronized level is stage SYNC_STAGES-1; the last stage is its history.
    assign edge_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

endmodule

// File: rtl/aa_zero_count.sv
module aa_zero_count #(
    parameter int unsigned LIMIT = 3,
    parameter int unsigned CW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_valid,
    input  logic          bit_in,
    input  logic          boundary,
    output logic [CW-1:0] cnt_o,
    output logic          enough_o
);
    localparam logic [CW-1:0] CAP = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          zero_hit;

    always_comb begin
        zero_hit = bit_valid & ~bit_in;
        cnt_d    = cnt_q;
        if (boundary) begin
            cnt_d = zero_hit ? CW'(1) : '0;
        end else if (zero_hit && (cnt_q < CAP)) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o    = cnt_q;
    assign enough_o = (cnt_q >= CAP);

endmodule

// File: rtl/aa_window_judge.sv
module aa_window_judge
    import aa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic boundary,
    input  logic enough,
    output logic alarm_o
);
    judge_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (boundary) begin
            if (st_q.hist_valid && !st_q.hist_enough && !enough) st_d.alarm = 1'b1;
            if (st_q.hist_valid &&  st_q.hist_enough &&  enough) st_d.alarm = 1'b0;
            st_d.hist_valid  = 1'b1;
            st_d.hist_enough = enough;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alarm_o = st_q.alarm;

endmodule

// File: rtl/allones_alarm.sv
module allones_alarm
    import aa_pkg::*;
#(
    parameter int unsigned ZERO_LIMIT  = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_in,
    input  logic win_strobe,
    output logic alarm
);
    localparam int unsigned CW = cnt_width(ZERO_LIMIT);

    logic          win_edge;
    logic [CW-1:0] zero_cnt;
    logic          win_enough;

    aa_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (win_strobe),
        .edge_o   (win_edge)
    );

    aa_zero_count #(.LIMIT(ZERO_LIMIT), .CW(CW)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .boundary  (win_edge),
        .cnt_o     (zero_cnt),
        .enough_o  (win_enough)
    );

    aa_window_judge u_judge (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (win_edge),
        .enough   (win_enough),
        .alarm_o  (alarm)
    );

endmodule

// File: rtl/aa_chk.sv
module aa_chk #(
    parameter int unsigned LIMIT = 3,
    parameter int unsigned CW    = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_valid,
    input logic          bit_in,
    input logic          boundary,
    input logic [CW-1:0] zcount,
    input logic          alarm
);
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        zcount <= CW'(LIMIT));

    p_one_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!boundary && !(bit_valid && !bit_in)) |=> $stable(zcount));

    p_zero_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!boundary && bit_valid && !bit_in && zcount < CW'(LIMIT))
        |=> zcount == $past(zcount) + CW'(1));

    p_single_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> !boundary);

    p_alarm_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(alarm));

    p_new_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && bit_valid && !bit_in) |=> zcount == CW'(1));

    p_new_window_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !(bit_valid && !bit_in)) |=> zcount == '0);

endmodule

bind allones_alarm aa_chk #(.LIMIT(ZERO_LIMIT), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .boundary  (win_edge),
    .zcount    (zero_cnt),
    .alarm     (alarm)
);

// File: tb/tb_allones_alarm.sv
`timescale 1ns/1ps
module tb_allones_alarm;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b1;
    logic win_strobe = 1'b0;
    logic alarm;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state of the requirements
    int m_cnt = 0;
    bit m_hv  = 1'b0;
    bit m_he  = 1'b0;
    bit m_alarm = 1'b0;

    always #5 clk = ~clk;

    allones_alarm dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_valid  (bit_valid),
        .bit_in     (bit_in),
        .win_strobe (win_strobe),
        .alarm      (alarm)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s alarm actual=%0b expected=%0b", tag, got, exp);
        end
    endtask

    function automatic bit model_close(input int cnt);
        bit enough;
        bit na;
        enough = (cnt >= 3);
        na = m_alarm;
        if (m_hv && !m_he && !enough) na = 1'b1;
        if (m_hv && m_he && enough)   na = 1'b0;
        m_hv = 1'b1;
        m_he = enough;
        return na;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_valid = 1'b0; win_strobe = 1'b0;
        m_cnt = 0; m_hv = 1'b0; m_he = 1'b0; m_alarm = 1'b0;
        repeat (3) @(negedge clk);
        check(alarm, 1'b0, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(alarm, 1'b0, "R1 after release");
    endtask

    task automatic send_bit(input bit v, input bit b);
        @(negedge clk);
        bit_valid = v; bit_in = b;
        if (v && !b && m_cnt < 3) m_cnt++;
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) begin
            send_bit(1'b1, 1'b1);
            send_bit(1'b1, 1'b0);
        end
    endtask

    // Raises the strobe; boundary lands on the third edge. Strobe stays high.
    task automatic close_window(input bit bv, input bit bb, input string tag);
        @(negedge clk);
        check(alarm, m_alarm, "R6 hold within window");
        win_strobe = 1'b1; bit_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bit_valid = bv; bit_in = bb;
        m_alarm = model_close(m_cnt);
        m_cnt = (bv && !bb) ? 1 : 0;
        @(negedge clk);
        bit_valid = 1'b0;
        check(alarm, m_alarm, tag);
    endtask

    task automatic strobe_low();
        @(negedge clk);
        win_strobe = 1'b0; bit_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic window(input int zeros, input string tag);
        send_zeros(zeros);
        send_bit(1'b1, 1'b1);
        close_window(1'b0, 1'b1, tag);
        strobe_low();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset();

        // R8: lone first window cannot set; R4: second short window sets
        window(0, "R8 first window no change");
        window(1, "R4 set after two short windows");
        // R6 mixed pair holds, R5 two full windows clear
        window(3, "R6 mixed pair holds");
        window(4, "R5 clear after two full windows");

        // R2: unqualified zeros are ignored
        send_zeros(2);
        for (int i = 0; i < 6; i++) send_bit(1'b0, 1'b0);
        close_window(1'b0, 1'b1, "R2 invalid zeros ignored (hold)");
        strobe_low();
        send_zeros(2);
        for (int i = 0; i < 6; i++) send_bit(1'b0, 1'b0);
        close_window(1'b0, 1'b1, "R2 invalid zeros ignored (set)");
        strobe_low();
        // R2 saturation: many zeros behave as three
        window(9, "R2 saturated window hold");
        window(7, "R2 saturated windows clear");

        // R7: zero in the boundary cycle starts the new window
        window(2, "R7 setup short window");
        send_zeros(2);
        close_window(1'b1, 1'b0, "R7 boundary zero not in old window");
        strobe_low();
        send_zeros(2);
        close_window(1'b0, 1'b1, "R7 carried zero completes window (hold)");
        strobe_low();
        window(3, "R7 clear after carried window");

        // R3: long strobe is one boundary; zeros sent while high stay in one window
        window(0, "R3 setup short window");
        send_zeros(1);
        close_window(1'b0, 1'b1, "R3 short pair sets");
        send_zeros(3);
        for (int i = 0; i < 10; i++) send_bit(1'b1, 1'b1);
        strobe_low();
        close_window(1'b0, 1'b1, "R3 held strobe single boundary");
        strobe_low();
        window(5, "R3 clear after held-strobe window");

        // R1 mid-run reset clears alarm and history
        window(0, "R1 setup");
        window(0, "R1 setup set");
        check(alarm, 1'b1, "R1 alarm high before reset");
        do_reset();
        window(0, "R1 history cleared after reset");

        // Random windows
        for (int w = 0; w < 80; w++) begin
            int nb;
            int pz;
            bit bv;
            bit bb;
            nb = $urandom_range(1, 14);
            case ($urandom_range(0, 3))
                0: pz = 0;
                1: pz = 12;
                2: pz = 30;
                default: pz = 60;
            endcase
            for (int i = 0; i < nb; i++)
                send_bit($urandom_range(0, 9) < 8, $urandom_range(0, 99) >= pz);
            bv = $urandom_range(0, 1);
            bb = $urandom_range(0, 1);
            close_window(bv, bb, "R4 R5 R6 R7 random window");
            if ($urandom_range(0, 3) == 0) begin
                for (int i = 0; i < 4; i++)
                    send_bit($urandom_range(0, 1), $urandom_range(0, 1));
            end
            strobe_low();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule